// File: doc/BRIEF.md
# Serial Flash Byte-Burst Engine

This block drives a serial flash device over a four-wire SPI link in mode 0. The host sees two 32-bit registers: a control register that starts a transfer and reports progress, and a word register that holds outgoing bytes before a transmit and received bytes after a receive. Each transfer moves one to four bytes in one direction.

A hold-select flag in the control register decides whether chip select is released when a transfer ends. Software builds any flash command from short bursts this way. A fast read, for example, is a 4-byte transmit with the opcode in the low byte and the byte-swapped 24-bit address above it, then a 1-byte receive that discards the dummy cycle, then one or more data receives. All of these run with chip select held, and only the final burst releases it. The block has no knowledge of the flash command set.

The serial clock comes from the system clock through a fixed divider of `2*HALF_DIV` system cycles per SCK period. SCK idles low, MOSI changes on falling edges, and MISO is sampled on rising edges.

Top module: `spi_xfer_ctrl`

## Requirements
- R1: After reset, cs_n is 1, sck is 0, mosi is 0, the control register reads 0 and the word register reads 0.
- R2: Control register layout (rd_sel/wr_sel = 0): bit 31 busy (read only), bit 0 direction (1 = transmit the word register, 0 = receive), bits 2:1 byte count minus one, bit 3 hold-select. All other bits read 0. Bits 3:0 read back the last accepted command.
- R3: While busy is 1, host writes to the control register and to the word register (wr_sel = 1) have no effect. A transmit leaves the word register unchanged.
- R4: A transmit sends bytes starting at the least significant byte of the word register, each byte MSB first. MOSI changes only while SCK is low.
- R5: A receive samples MISO on each SCK rising edge. Received bytes are placed in the word register from the least significant byte upward, unused upper bytes read 0, and MOSI stays 0 for the whole transfer.
- R6: SCK is 0 whenever the block is idle. The first rising edge comes HALF_DIV system cycles after the command is accepted, and the SCK period is 2*HALF_DIV system cycles.
- R7: With hold-select set, busy clears on the last falling SCK edge, 16*N*HALF_DIV cycles after acceptance for N bytes, and cs_n stays 0.
- R8: With hold-select clear, cs_n returns to 1 one SCK period after the last falling edge, and busy clears in that same cycle, 16*N*HALF_DIV + 2*HALF_DIV cycles after acceptance.
- R9: Accepting a command drives cs_n to 0 in the same cycle. A chain of held bursts (4-byte opcode/address transmit, 1-byte dummy receive, 4-byte data receive) produces exactly one cs_n rising edge, at the end of the chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 word |
| wr_data | input | 32 | Host write data |
| rd_sel | input | 1 | Read source: 0 control, 1 word |
| rd_data | output | 32 | Host read data (combinational) |
| sck | output | 1 | Serial clock to flash |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |

## Verification
The embedded assertions check several rules on every cycle. SCK stays low when idle. Chip select is held low throughout shifting. MOSI is stable while SCK is high and is zero during receives. The latched command and the transmit word are frozen while busy. Chip select releases only at the point where busy clears. Only the bench scenarios can show the byte and bit order on the wire, where received bytes land in the word register, the exact busy durations with and without hold-select, and that a held chain produces a single chip-select release. The bench sweeps every direction, count and hold-select combination against a behavioural flash model.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

  localparam int WORD_W      = 32;
  localparam int OP_DIR_BIT  = 0;
  localparam int OP_CNT_LSB  = 1;
  localparam int OP_HOLD_BIT = 3;
  localparam int OP_BUSY_BIT = 31;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_TAIL  = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic       hold;
    logic [1:0] cnt_m1;
    logic       tx_dir;
  } op_cfg_t;

  function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

endpackage

// File: rtl/spi_sck_div.sv
module spi_sck_div #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] TOP = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == TOP);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOP); // R6
  AST_DIV_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> (cnt_q == '0)); // R6

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_xfer_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         rise_tick,
  input  logic         fall_tick,
  input  logic         miso,
  input  logic [1:0]   cnt_m1,
  output logic         tx_bit,
  output logic [W-1:0] rx_word
);
  logic [W-1:0] tx_q, tx_d;
  logic [W-1:0] rx_q, rx_d;
  logic [W-1:0] rx_aligned;

  always_comb begin
    tx_d = tx_q;
    if (load)           tx_d = swap_bytes(load_val);
    else if (fall_tick) tx_d = {tx_q[W-2:0], 1'b0};
  end

  always_comb begin
    rx_d = rx_q;
    if (load)           rx_d = '0;
    else if (rise_tick) rx_d = {rx_q[W-2:0], miso};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end

  // first received byte moved to the top, then byte order reversed
  assign rx_aligned = rx_q << {~cnt_m1, 3'b000};
  assign rx_word    = swap_bytes(rx_aligned);
  assign tx_bit     = tx_q[W-1];

  AST_TX_HOLDS_OFF_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !fall_tick) |=> $stable(tx_q)); // R4
  AST_RX_HOLDS_OFF_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !rise_tick) |=> $stable(rx_q)); // R5

endmodule

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl
  import spi_xfer_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [WORD_W-1:0] rd_data,
  output logic              sck,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso
);
  localparam int BCW = $clog2(WORD_W);

  seq_state_t        state_q, state_d;
  op_cfg_t           op_q, op_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic [BCW-1:0]    bit_q, bit_d;
  logic              sck_q, sck_d;
  logic              cs_n_q, cs_n_d;
  logic              tail_q, tail_d;

  logic              busy, start, word_wr, tick;
  logic              rise_tick, fall_tick, last_bit;
  logic              tx_bit;
  logic [WORD_W-1:0] rx_word, load_val;

  assign busy     = (state_q != ST_IDLE);
  assign start    = wr_en && !wr_sel && !busy;
  assign word_wr  = wr_en &&  wr_sel && !busy;
  assign load_val = wr_data[OP_DIR_BIT] ? word_q : '0;

  spi_sck_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .tick  (tick)
  );

  assign rise_tick = tick && (state_q == ST_SHIFT) && !sck_q;
  assign fall_tick = tick && (state_q == ST_SHIFT) &&  sck_q;
  assign last_bit  = (bit_q == {op_q.cnt_m1, 3'b111});

  spi_shift_core #(.W(WORD_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start),
    .load_val  (load_val),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .miso      (miso),
    .cnt_m1    (op_q.cnt_m1),
    .tx_bit    (tx_bit),
    .rx_word   (rx_word)
  );

  always_comb begin
    state_d = state_q;
    op_d    = op_q;
    word_d  = word_q;
    bit_d   = bit_q;
    sck_d   = sck_q;
    cs_n_d  = cs_n_q;
    tail_d  = tail_q;
    unique case (state_q)
      ST_IDLE: begin
        if (word_wr) word_d = wr_data;
        if (start) begin
          op_d.tx_dir = wr_data[OP_DIR_BIT];
          op_d.cnt_m1 = wr_data[OP_CNT_LSB +: 2];
          op_d.hold   = wr_data[OP_HOLD_BIT];
          bit_d       = '0;
          cs_n_d      = 1'b0;
          state_d     = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (rise_tick) sck_d = 1'b1;
        if (fall_tick) begin
          sck_d = 1'b0;
          if (last_bit) begin
            if (!op_q.tx_dir) word_d = rx_word;
            tail_d  = 1'b0;
            state_d = op_q.hold ? ST_IDLE : ST_TAIL;
          end else begin
            bit_d = bit_q + 1'b1;
          end
        end
      end
      ST_TAIL: begin
        if (tick) begin
          if (tail_q) begin
            cs_n_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            tail_d = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      word_q  <= '0;
      bit_q   <= '0;
      sck_q   <= 1'b0;
      cs_n_q  <= 1'b1;
      tail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      word_q  <= word_d;
      bit_q   <= bit_d;
      sck_q   <= sck_d;
      cs_n_q  <= cs_n_d;
      tail_q  <= tail_d;
    end
  end

  assign sck  = sck_q;
  assign cs_n = cs_n_q;
  assign mosi = (state_q == ST_SHIFT) && tx_bit;

  always_comb begin
    if (rd_sel) rd_data = word_q;
    else begin
      rd_data = '0;
      rd_data[OP_BUSY_BIT]       = busy;
      rd_data[OP_DIR_BIT]        = op_q.tx_dir;
      rd_data[OP_CNT_LSB +: 2]   = op_q.cnt_m1;
      rd_data[OP_HOLD_BIT]       = op_q.hold;
    end
  end

  AST_SCK_LOW_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !sck); // R6
  AST_CS_LOW_WHILE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SHIFT) |-> !cs_n); // R7
  AST_CS_RISE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> !busy); // R8
  AST_MOSI_STABLE_SCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi)); // R4
  AST_MOSI_ZERO_ON_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !op_q.tx_dir) |-> !mosi); // R5
  AST_CMD_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(op_q)); // R3
  AST_TX_WORD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q.tx_dir && $past(busy)) |-> $stable(word_q)); // R3

endmodule

// File: tb/spi_xfer_ctrl_test.sv
module spi_xfer_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int H = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_sel = 1'b0;
  logic [31:0] rd_data;
  logic        sck, cs_n, mosi, miso;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  spi_xfer_ctrl #(.HALF_DIV(H)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // flash model
  logic [31:0] slv_tx = '0;
  int          sb = 0, sb_base = 0;
  int          rb = 0, rb_base = 0;
  logic [31:0] hist = '0;
  time         t_r0 = 0, t_r1 = 0;
  int          cs_rises = 0;

  always @(negedge sck) sb = sb + 1;
  always @(posedge sck) begin
    if (rb - rb_base == 0) t_r0 = $time;
    if (rb - rb_base == 1) t_r1 = $time;
    hist = {hist[30:0], mosi};
    rb = rb + 1;
  end
  always @(posedge cs_n) cs_rises = cs_rises + 1;

  function automatic logic slave_bit(int k, logic [31:0] v);
    if (k < 0 || k > 31) return 1'b0;
    return v[(k/8)*8 + 7 - (k%8)];
  endfunction
  assign miso = slave_bit(sb - sb_base, slv_tx);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(logic sel, logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_reg(logic sel, output logic [31:0] v);
    rd_sel = sel;
    #1 v = rd_data;
  endtask

  task automatic run_op(logic dir, int n, logic hold, logic [31:0] pat);
    logic [31:0] opw, v, mask, expw, jmp;
    time t_start;
    int c0, t_exp;
    mask = (n == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8*n)) - 1);
    host_write(1'b1, pat);
    slv_tx = ~pat ^ 32'h5A5A_5A5A;
    sb_base = sb; rb_base = rb;
    opw = {28'b0, hold, 2'(n-1), dir};
    host_write(1'b0, opw);
    t_start = $time - CLK_PERIOD/2;
    c0 = cyc;
    check("R9 cs_n low on accept", {31'b0, cs_n}, 32'h0);
    read_reg(1'b0, v);
    check("R2 control readback busy", v, {1'b1, 27'b0, opw[3:0]});
    host_write(1'b1, 32'hDEAD_BEEF);
    jmp = {28'b0, ~opw[3:0]};
    host_write(1'b0, jmp);
    rd_sel = 1'b0;
    #1;
    while (rd_data[31]) begin @(negedge clk); #1; end
    t_exp = 16*n*H + (hold ? 0 : 2*H);
    if (hold) check("R7 busy length held", cyc - c0, t_exp);
    else      check("R8 busy length released", cyc - c0, t_exp);
    if (hold) check("R7 cs_n stays low", {31'b0, cs_n}, 32'h0);
    else      check("R8 cs_n released", {31'b0, cs_n}, 32'h1);
    check("R6 sck idle low", {31'b0, sck}, 32'h0);
    check("R6 first rise delay", 32'(t_r0 - t_start), 32'(H*CLK_PERIOD));
    check("R6 sck period", 32'(t_r1 - t_r0), 32'(2*H*CLK_PERIOD));
    read_reg(1'b0, v);
    check("R3 control write ignored while busy", v, {28'b0, opw[3:0]});
    read_reg(1'b1, v);
    if (dir) begin
      check("R3 word unchanged by transmit", v, pat);
      expw = '0;
      for (int i = 0; i < n; i++) expw[(n-1-i)*8 +: 8] = pat[i*8 +: 8];
      check("R4 bytes on mosi", hist & mask, expw);
    end else begin
      check("R5 received word", v, slv_tx & mask);
      check("R5 mosi low on receive", hist & mask, 32'h0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] pats [2];
    int r0;
    pats[0] = 32'hA5C3_0F96;
    pats[1] = 32'h1E2D_3C4B;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    read_reg(1'b0, v); check("R1 control reset", v, 32'h0);
    read_reg(1'b1, v); check("R1 word reset", v, 32'h0);
    check("R1 pins reset", {29'b0, cs_n, sck, mosi}, 32'h4);

    for (int p = 0; p < 2; p++)
      for (int d = 0; d < 2; d++)
        for (int n = 1; n <= 4; n++)
          for (int h = 0; h < 2; h++)
            run_op(d[0], n, h[0], pats[p] ^ {8'(n), 8'(d), 8'(h), 8'(p)});
    run_op(1'b1, 1, 1'b0, 32'h0000_00C7);
    check("R8 cs_n high before chain", {31'b0, cs_n}, 32'h1);

    // held chain: opcode + swapped address, dummy, data
    r0 = cs_rises;
    run_op(1'b1, 4, 1'b1, {8'h56, 8'h34, 8'h12, 8'h0B});
    run_op(1'b0, 1, 1'b1, 32'h0);
    check("R9 no release mid chain", 32'(cs_rises - r0), 32'h0);
    run_op(1'b0, 4, 1'b0, 32'h7777_1111);
    check("R9 single release for chain", 32'(cs_rises - r0), 32'h1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule